// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block manages 128 general-purpose pins behind a 32-bit register port. Every pin owns one configuration word. The word holds the value the pin drives, the synchronized value seen on the pin, separate disables for the output driver and the input receiver, and a 4-bit trigger-mode field. Pin events are collected into four status banks of 32 bits each, with a matching enable bank for each. A single interrupt line goes high whenever any pin has both its status bit and its enable bit set. Lock bits are fixed at build time. Each lock bit freezes the configuration word of its pin against writes.

Software writes a pin's word to drive it or to change its trigger mode. It reads a status bank to find the pending pins. It clears a status bit with a read-modify-write that writes 0 to that bit and 1 to the others. The register port has no back-pressure: a write is accepted on every clock edge where the write enable is high. Reads are combinational from the word address. The region offset register, the lock banks and the sampled-input bit are read-only.

Top module: `gpio_ctl`

Address map. The port carries the byte address divided by four. The byte offsets below are relative to the region base, which defaults to 0x400, except for the first entry.

| Byte offset | Register |
|---|---|
| 0x000 (absolute) | Region base, read-only |
| 0x04 + 4·b | Lock bank b |
| 0x20 + 8·b | Status bank b |
| 0x24 + 8·b | Enable bank b |
| 0x200 + 4·p | Configuration word of pin p |

Any other address reads 0. Pin p sits in bank p/32 at bit p mod 32.

## Requirements
- R1: The word at byte address 0x000 reads the region base, 0x400 by default, and writes to it have no effect.
- R2: The registers answer at the byte offsets in the address map above, measured from the region base, and unmapped addresses read 0.
- R3: In a configuration word, bit 0 (drive value), bit 3 (output disable), bit 4 (receiver disable) and bits 25:22 (trigger code) are read/write. Bit 1 reads the synchronized pin input, or 0 while bit 4 is set. All other bits read 0.
- R4: pin_out_o[p] equals bit 0 of pin p's word, and pin_oe_o[p] is the inverse of bit 3. Both follow the clock edge on which the word is written.
- R5: A change on pin_in_i reaches bit 1 of the word after two rising clock edges.
- R6: Lock bank b reads bits 32b+31..32b of the lock parameter, and writes to it are ignored. A write to the word of a pin whose lock bit is set leaves that word unchanged.
- R7: With trigger code 1 (rising edge), a 0-to-1 change of the synchronized, receiver-gated input sets the pin's status bit on the next edge. This is the third edge after the pin changes. The bit stays set when 1 is written to it and clears when 0 is written. If an edge event and a clearing write land on the same edge, the bit ends up set.
- R8: With trigger code 0 (level high), the status bit is set on every edge on which the synchronized input is high, so clearing it does not hold while the input stays high.
- R9: Trigger code 2 (disabled) and the unused codes 3 to 15 never set a status bit.
- R10: irq_o is high exactly when some status bit and its enable bit are both set. It changes in the same cycle as the registers feeding it.
- R11: After reset every configuration word reads 0x0080_0000 (trigger code 2, everything else 0), and all status and enable banks read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 10 | Word address (byte address / 4) |
| reg_wr_en_i | input | 1 | Write strobe, one word per edge |
| reg_wr_data_i | input | 32 | Write data |
| reg_rd_data_o | output | 32 | Combinational read data for reg_addr_i |
| pin_in_i | input | 128 | Asynchronous pin inputs |
| pin_out_o | output | 128 | Pin drive values |
| pin_oe_o | output | 128 | Pin output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
A register write shows on the read port, pin_out_o and pin_oe_o in the low phase right after the edge that takes it. A pin change reaches bit 1 two edges later, and reaches the status bank and irq_o three edges later. The bench holds a behavioural reference model that is advanced on the same edges and compared against every output in the middle of each low phase. The directed checks place each read one low phase after the edge under test, and they time a clearing write so that it lands exactly on the third edge after a rising pin change.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;

  localparam int DATA_W       = 32;
  localparam int TRIG_W       = 4;
  localparam int CFG_OUT_BIT  = 0;
  localparam int CFG_IN_BIT   = 1;
  localparam int CFG_TXD_BIT  = 3;
  localparam int CFG_RXD_BIT  = 4;
  localparam int CFG_TRIG_LSB = 22;

  // word offsets inside the pin region
  localparam int LOCK_WORD = 1;
  localparam int STAT_WORD = 8;
  localparam int CFG_WORD  = 128;

  localparam logic [TRIG_W-1:0] TRIG_LEVEL = 4'd0;
  localparam logic [TRIG_W-1:0] TRIG_RISE  = 4'd1;
  localparam logic [TRIG_W-1:0] TRIG_OFF   = 4'd2;

  typedef struct packed {
    logic [TRIG_W-1:0] trig;
    logic              rxdis;
    logic              txdis;
    logic              drive;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{trig: TRIG_OFF, rxdis: 1'b0, txdis: 1'b0, drive: 1'b0};

  function automatic pin_cfg_t word_to_cfg(input logic [DATA_W-1:0] w);
    pin_cfg_t c;
    c.trig  = w[CFG_TRIG_LSB +: TRIG_W];
    c.rxdis = w[CFG_RXD_BIT];
    c.txdis = w[CFG_TXD_BIT];
    c.drive = w[CFG_OUT_BIT];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_to_word(input pin_cfg_t c, input logic seen);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CFG_TRIG_LSB +: TRIG_W] = c.trig;
    w[CFG_RXD_BIT] = c.rxdis;
    w[CFG_TXD_BIT] = c.txdis;
    w[CFG_IN_BIT]  = seen;
    w[CFG_OUT_BIT] = c.drive;
    return w;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_ctl_pkg::*;
#(
  parameter int               NPINS     = 128,
  parameter logic [NPINS-1:0] LOCK_MASK = '0,
  localparam int              IDX_W     = $clog2(NPINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  pin_cfg_t               wr_cfg_i,
  input  logic [NPINS-1:0]       sync_i,
  output pin_cfg_t [NPINS-1:0]   cfg_o,
  output logic [NPINS-1:0]       seen_o,
  output logic [NPINS-1:0]       ev_o
);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_cfg_t c_q;
    logic     gated;
    logic     gated_q;
    logic     hit;

    assign hit = wr_en_i && (wr_idx_i == IDX_W'(p));

    if (LOCK_MASK[p]) begin : g_locked
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= CFG_RESET;
        else        c_q <= c_q;
      end

      assert_locked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> $stable(c_q));
    end else begin : g_open
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   c_q <= CFG_RESET;
        else if (hit) c_q <= wr_cfg_i;
      end

      assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cfg_o[p] == $past(wr_cfg_i)));
    end

    assign gated = sync_i[p] & ~c_q.rxdis;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gated_q <= 1'b0;
      else        gated_q <= gated;
    end

    always_comb begin
      unique case (c_q.trig)
        TRIG_LEVEL: ev_o[p] = gated;
        TRIG_RISE:  ev_o[p] = gated & ~gated_q;
        default:    ev_o[p] = 1'b0;
      endcase
    end

    assign cfg_o[p]  = c_q;
    assign seen_o[p] = gated;

    assert_off_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_o[p].trig != TRIG_LEVEL && cfg_o[p].trig != TRIG_RISE) |-> !ev_o[p]);
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NBANKS = 4,
  parameter int BANK_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NBANKS-1:0]             st_wr_i,
  input  logic [NBANKS-1:0]             en_wr_i,
  input  logic [BANK_W-1:0]             wr_data_i,
  input  logic [NBANKS-1:0][BANK_W-1:0] ev_i,
  output logic [NBANKS-1:0][BANK_W-1:0] status_o,
  output logic [NBANKS-1:0][BANK_W-1:0] enable_o,
  output logic                          irq_o
);

  logic [NBANKS-1:0] bank_hot;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [BANK_W-1:0] st_q;
    logic [BANK_W-1:0] en_q;
    logic [BANK_W-1:0] st_kept;

    // software clears with 0, keeps with 1; a same-edge event wins
    assign st_kept = st_wr_i[b] ? (st_q & wr_data_i) : st_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= '0;
        en_q <= '0;
      end else begin
        st_q <= st_kept | ev_i[b];
        if (en_wr_i[b]) en_q <= wr_data_i;
      end
    end

    assign status_o[b] = st_q;
    assign enable_o[b] = en_q;
    assign bank_hot[b] = |(st_q & en_q);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !st_wr_i[b] |=> (($past(st_q) & ~st_q) == '0));

    assert_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_i[b]) |=> ((st_q & $past(ev_i[b])) == $past(ev_i[b])));
  end

  assign irq_o = |bank_hot;

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|status_o));

endmodule

// File: rtl/gpio_ctl.sv
module gpio_ctl
  import gpio_ctl_pkg::*;
#(
  parameter int               NPINS      = 128,
  parameter int               BANK_W     = 32,
  parameter int               ADDR_W     = 10,
  parameter int               REGION_OFS = 32'h400,
  parameter logic [NPINS-1:0] LOCK_MASK  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_en_i,
  input  logic [31:0]       reg_wr_data_i,
  output logic [31:0]       reg_rd_data_o,
  input  logic [NPINS-1:0]  pin_in_i,
  output logic [NPINS-1:0]  pin_out_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);

  localparam int NBANKS = NPINS / BANK_W;
  localparam int IDX_W  = $clog2(NPINS);
  localparam int BK_W   = (NBANKS > 1) ? $clog2(NBANKS) : 1;

  localparam logic [ADDR_W-1:0] A_REGION   = ADDR_W'(REGION_OFS / 4);
  localparam logic [ADDR_W-1:0] A_LOCK     = ADDR_W'(LOCK_WORD);
  localparam logic [ADDR_W-1:0] A_LOCK_END = ADDR_W'(LOCK_WORD + NBANKS);
  localparam logic [ADDR_W-1:0] A_STAT     = ADDR_W'(STAT_WORD);
  localparam logic [ADDR_W-1:0] A_STAT_END = ADDR_W'(STAT_WORD + 2 * NBANKS);
  localparam logic [ADDR_W-1:0] A_CFG      = ADDR_W'(CFG_WORD);
  localparam logic [ADDR_W-1:0] A_CFG_END  = ADDR_W'(CFG_WORD + NPINS);

  // ---- address decode ----
  logic              in_region;
  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] bank_off;
  logic              hit_lock, hit_bank, hit_cfg, pick_en;
  logic [BK_W-1:0]   lock_bk, stat_bk;
  logic [IDX_W-1:0]  pin_idx;

  assign in_region = (reg_addr_i >= A_REGION);
  assign rel       = reg_addr_i - A_REGION;
  assign bank_off  = rel - A_STAT;
  assign hit_lock  = in_region && (rel >= A_LOCK) && (rel < A_LOCK_END);
  assign hit_bank  = in_region && (rel >= A_STAT) && (rel < A_STAT_END);
  assign hit_cfg   = in_region && (rel >= A_CFG)  && (rel < A_CFG_END);
  assign lock_bk   = BK_W'(rel - A_LOCK);
  assign stat_bk   = BK_W'(bank_off >> 1);
  assign pick_en   = bank_off[0];
  assign pin_idx   = IDX_W'(rel - A_CFG);

  // ---- pin path ----
  logic [NPINS-1:0]     sync_in;
  pin_cfg_t [NPINS-1:0] cfg;
  logic [NPINS-1:0]     seen;
  logic [NPINS-1:0]     ev;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_in_i),
    .q_o   (sync_in)
  );

  gpio_pin_cfg #(.NPINS(NPINS), .LOCK_MASK(LOCK_MASK)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (reg_wr_en_i && hit_cfg),
    .wr_idx_i (pin_idx),
    .wr_cfg_i (word_to_cfg(reg_wr_data_i)),
    .sync_i   (sync_in),
    .cfg_o    (cfg),
    .seen_o   (seen),
    .ev_o     (ev)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_drive
    assign pin_out_o[p] = cfg[p].drive;
    assign pin_oe_o[p]  = ~cfg[p].txdis;
  end

  // ---- interrupt banks ----
  logic [NBANKS-1:0]             st_wr, en_wr;
  logic [NBANKS-1:0][BANK_W-1:0] ev_b, status, enable;

  assign ev_b = ev;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bwr
    assign st_wr[b] = reg_wr_en_i && hit_bank && !pick_en && (stat_bk == BK_W'(b));
    assign en_wr[b] = reg_wr_en_i && hit_bank &&  pick_en && (stat_bk == BK_W'(b));
  end

  gpio_irq_bank #(.NBANKS(NBANKS), .BANK_W(BANK_W)) u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_wr_i   (st_wr),
    .en_wr_i   (en_wr),
    .wr_data_i (reg_wr_data_i[BANK_W-1:0]),
    .ev_i      (ev_b),
    .status_o  (status),
    .enable_o  (enable),
    .irq_o     (irq_o)
  );

  // ---- read mux ----
  always_comb begin
    reg_rd_data_o = '0;
    if (reg_addr_i == '0)
      reg_rd_data_o = 32'(REGION_OFS);
    else if (hit_lock)
      reg_rd_data_o = 32'(LOCK_MASK[lock_bk * BANK_W +: BANK_W]);
    else if (hit_bank)
      reg_rd_data_o = pick_en ? 32'(enable[stat_bk]) : 32'(status[stat_bk]);
    else if (hit_cfg)
      reg_rd_data_o = cfg_to_word(cfg[pin_idx], seen[pin_idx]);
  end

  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|enable));

  assert_oe_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en_i && hit_cfg && !LOCK_MASK[pin_idx]) |=>
      (pin_oe_o[$past(pin_idx)] == !$past(reg_wr_data_i[CFG_TXD_BIT])));

endmodule

// File: tb/gpio_ctl_bench.sv
module gpio_ctl_bench;

  localparam logic [127:0] LOCKS = (128'd1 << 100) | (128'd1 << 5);
  localparam int RB = 256;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [9:0]   addr = '0;
  logic         we = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_out, pin_oe;
  logic         irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_ctl #(.LOCK_MASK(LOCKS)) u_gpio_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr_i    (addr),
    .reg_wr_en_i   (we),
    .reg_wr_data_i (wdata),
    .reg_rd_data_o (rdata),
    .pin_in_i      (pin_in),
    .pin_out_o     (pin_out),
    .pin_oe_o      (pin_oe),
    .irq_o         (irq)
  );

  function automatic logic [9:0] CFG(int p); return 10'(RB + 128 + p); endfunction
  function automatic logic [9:0] LK(int b);  return 10'(RB + 1 + b);   endfunction
  function automatic logic [9:0] ST(int b);  return 10'(RB + 8 + 2*b); endfunction
  function automatic logic [9:0] EN(int b);  return 10'(RB + 9 + 2*b); endfunction

  // ---------------- behavioural reference model ----------------
  bit        m_drv[128], m_tx[128], m_rx[128], m_s1[128], m_s2[128], m_gq[128];
  bit [3:0]  m_tr[128];
  bit [31:0] m_st[4], m_en[4];

  function automatic logic [31:0] model_read(int a);
    int r;
    logic [31:0] w;
    if (a == 0) return 32'h400;
    if (a < RB) return 0;
    r = a - RB;
    if (r >= 1 && r <= 4) return LOCKS[(r-1)*32 +: 32];
    if (r >= 8 && r < 16) return (r % 2) ? m_en[(r-8)/2] : m_st[(r-8)/2];
    if (r >= 128 && r < 256) begin
      w = 0;
      w[0] = m_drv[r-128];
      w[1] = m_s2[r-128] && !m_rx[r-128];
      w[3] = m_tx[r-128];
      w[4] = m_rx[r-128];
      w[25:22] = m_tr[r-128];
      return w;
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 128; p++) begin
        m_drv[p] = 0; m_tx[p] = 0; m_rx[p] = 0; m_tr[p] = 4'd2;
        m_s1[p] = 0; m_s2[p] = 0; m_gq[p] = 0;
      end
      for (int b = 0; b < 4; b++) begin m_st[b] = 0; m_en[b] = 0; end
    end else begin
      bit g[128];
      bit e[128];
      int r;
      for (int p = 0; p < 128; p++) begin
        g[p] = m_s2[p] && !m_rx[p];
        e[p] = (m_tr[p] == 4'd1 && g[p] && !m_gq[p]) || (m_tr[p] == 4'd0 && g[p]);
      end
      if (we && int'(addr) >= RB) begin
        r = int'(addr) - RB;
        if (r >= 128 && r < 256 && !LOCKS[r-128]) begin
          m_drv[r-128] = wdata[0]; m_tx[r-128] = wdata[3];
          m_rx[r-128] = wdata[4];  m_tr[r-128] = wdata[25:22];
        end
        if (r >= 8 && r < 16) begin
          if (r % 2) m_en[(r-8)/2] = wdata;
          else       m_st[(r-8)/2] = m_st[(r-8)/2] & wdata;
        end
      end
      for (int p = 0; p < 128; p++) begin
        if (e[p]) m_st[p/32][p%32] = 1'b1;
        m_gq[p] = g[p];
        m_s2[p] = m_s1[p];
        m_s1[p] = pin_in[p];
      end
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison in the middle of the low phase
  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      logic [127:0] eo, ee;
      logic         ei;
      ei = 1'b0;
      for (int p = 0; p < 128; p++) begin
        eo[p] = m_drv[p];
        ee[p] = !m_tx[p];
      end
      for (int b = 0; b < 4; b++) ei = ei | (|(m_st[b] & m_en[b]));
      chk("R2 model read", 128'(rdata), 128'(model_read(int'(addr))));
      chk("R4 model pin_out", pin_out, eo);
      chk("R4 model pin_oe", pin_oe, ee);
      chk("R10 model irq", 128'(irq), 128'(ei));
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [9:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(tag, 128'(rdata), 128'(exp));
  endtask

  task automatic setpin(input int p, input logic v);
    @(negedge clk); pin_in[p] = v;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1..none actual=running expected=finished");
      done = 1'b1;
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd_chk("R11 reset cfg pin0", CFG(0), 32'h0080_0000);
    rd_chk("R11 reset status bank0", ST(0), 32'h0);
    rd_chk("R11 reset enable bank3", EN(3), 32'h0);
    chk("R4 reset oe", pin_oe, '1);

    rd_chk("R1 region base", 10'd0, 32'h400);
    wr(10'd0, 32'hFFFF);
    rd_chk("R1 region base after write", 10'd0, 32'h400);
    rd_chk("R2 unmapped", 10'(RB + 2000/4 - 400), 32'h0);

    rd_chk("R6 lock bank0", LK(0), 32'h20);
    rd_chk("R6 lock bank3", LK(3), 32'h10);
    wr(LK(0), 32'h0);
    rd_chk("R6 lock bank0 after write", LK(0), 32'h20);
    wr(CFG(5), 32'h1);
    rd_chk("R6 locked pin word", CFG(5), 32'h0080_0000);
    chk("R6 locked pin drive", 128'(pin_out[5]), 128'(0));

    wr(CFG(7), 32'hFFFF_FFFF);
    rd_chk("R3 field mask", CFG(7), 32'h03C0_0019);
    chk("R4 drive high", 128'(pin_out[7]), 128'(1));
    chk("R4 oe off", 128'(pin_oe[7]), 128'(0));
    wr(CFG(7), 32'h0080_0001);
    chk("R4 oe on", 128'(pin_oe[7]), 128'(1));

    wr(CFG(9), 32'h0080_0000);
    setpin(9, 1'b1);
    rd_chk("R5 one edge", CFG(9), 32'h0080_0000);
    rd_chk("R5 two edges", CFG(9), 32'h0080_0002);
    wr(CFG(9), 32'h0080_0010);
    rd_chk("R3 receiver off", CFG(9), 32'h0080_0010);

    wr(CFG(40), 32'h0040_0000);
    wr(EN(1), 32'h100);
    setpin(40, 1'b1);
    rd_chk("R7 edge1", ST(1), 32'h0);
    rd_chk("R7 edge2", ST(1), 32'h0);
    rd_chk("R7 edge3", ST(1), 32'h100);
    chk("R10 irq set", 128'(irq), 128'(1));
    wr(ST(1), 32'hFFFF_FFFF);
    rd_chk("R7 write one keeps", ST(1), 32'h100);
    wr(ST(1), 32'h0);
    rd_chk("R7 write zero clears", ST(1), 32'h0);
    chk("R10 irq cleared", 128'(irq), 128'(0));
    setpin(40, 1'b0);
    repeat (3) @(negedge clk);
    setpin(40, 1'b1);
    @(negedge clk);
    wr(ST(1), 32'h0);
    rd_chk("R7 edge beats clear", ST(1), 32'h100);
    wr(EN(1), 32'h0);
    chk("R10 masked", 128'(irq), 128'(0));

    wr(CFG(12), 32'h00C0_0000);
    wr(EN(0), 32'h1000);
    setpin(12, 1'b1);
    repeat (4) @(negedge clk);
    rd_chk("R9 unused code silent", ST(0), 32'h0);
    chk("R9 no irq", 128'(irq), 128'(0));

    wr(CFG(70), 32'h0);
    setpin(70, 1'b1);
    repeat (3) @(negedge clk);
    rd_chk("R8 level sets", ST(2), 32'h40);
    chk("R10 not enabled", 128'(irq), 128'(0));
    wr(EN(2), 32'h40);
    chk("R10 enabled", 128'(irq), 128'(1));
    wr(ST(2), 32'h0);
    rd_chk("R8 re-set after clear", ST(2), 32'h40);
    setpin(70, 1'b0);
    repeat (3) @(negedge clk);
    wr(ST(2), 32'h0);
    rd_chk("R8 clear once low", ST(2), 32'h0);
    chk("R10 irq low", 128'(irq), 128'(0));

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
  end

endmodule